// File: doc/BRIEF.md
# DMA Channel Transfer Sequencer

This block is a single DMA channel. Once loaded with a source address, a destination address and a unit count, it moves data over a simple internal bus master port. A bus cycle is held until the slave returns ready. In dual-address mode each unit is a read from the source followed by a write of the same data to the destination. In single-address mode each unit is one bus cycle, and an external device supplies or takes the data under a DACK strobe.

A small configuration register holds the channel settings:
- **Unit size:** byte, 2-byte word, 4-byte longword, or a 16-byte block that is carried out as four longword beats.
- **Request source:** internal auto-request, or an external request pin that is detected either on its rising edge or by its level.
- **Acknowledge mode:** in dual-address mode it picks whether DACK marks the read cycle or the write cycle. In single-address mode it picks the direction: memory to device or device to memory.
- **Address increments:** one enable for the source address and one for the destination address.

A full standby clears the configuration. A module-stop input freezes progress but keeps the settings.

Top module: `dma_chan_seq`

## Requirements
- R1: Size codes 00, 01 and 10 select 1-, 2- and 4-byte units. `bus_size_o` carries the same code. After each completed bus cycle, an address whose increment is enabled grows by 1, 2 or 4. An address whose increment is disabled stays fixed.
- R2: Size code 11 runs four longword bus transfers per request (`bus_size_o` = 10, address step 4). The count is decremented only once for the whole block.
- R3: Size 11 combined with external level detection (auto bit 0, level bit 1) sets `illegal_o`. While that holds, no bus cycle starts and `done_o` stays low. Size 11 with auto-request is legal.
- R4: With the auto bit at 1, units run one after another without any external request until the count reaches zero.
- R5: In edge mode (auto 0, level 0), each rising edge of `dreq_i` starts exactly one unit. This takes effect after a two-stage synchronizer. Holding `dreq_i` high does not start further units.
- R6: In level mode (auto 0, level 1), a unit starts whenever the synchronized `dreq_i` is high while the channel is idle. The request is sampled again after every unit. No unit starts while `dreq_i` is low.
- R7: In dual-address mode a unit reads at the source address (`bus_we_o` = 0) and then writes the data it read to the destination address (`bus_we_o` = 1). `dack_o` is high throughout the read cycle when the acknowledge mode is 0, and throughout the write cycle when it is 1.
- R8: In single-address mode every bus cycle has `dack_o` high. With acknowledge mode 0, the cycle is a read at the source address (memory to device) and only the source advances. With acknowledge mode 1, the cycle is a write at the destination address (device to memory) and only the destination advances.
- R9: A bus cycle keeps `bus_req_o`, `bus_addr_o` and `bus_we_o` steady until a clock edge at which `bus_rdy_i` is high.
- R10: `cnt_o` drops by one per completed unit. When the channel is running and idle with a count of zero, `done_o` rises and no further bus cycle starts. A start with a count of zero finishes with no bus cycle.
- R11: Reset clears every output to 0. A pulse on `standby_i` clears the size, auto-request, acknowledge-mode and other configuration fields to 0. After that pulse, a started channel waits for an external edge and moves bytes with DACK on the read.
- R12: While `mstop_i` is high, no unit starts and `done_o` does not rise. After release, the channel runs with the configuration written before the stop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| standby_i | input | 1 | Full standby: clears configuration, aborts and disables the channel |
| mstop_i | input | 1 | Module stop: freezes progress, keeps configuration |
| cfg_we_i | input | 1 | Writes the configuration fields (accepted when idle) |
| cfg_size_i | input | 2 | Unit size code |
| cfg_auto_i | input | 1 | 1 = auto-request, 0 = external request |
| cfg_ackm_i | input | 1 | Acknowledge / direction mode |
| cfg_single_i | input | 1 | 1 = single-address, 0 = dual-address |
| cfg_level_i | input | 1 | External request detection: 1 = level, 0 = rising edge |
| cfg_sinc_i | input | 1 | Source address increment enable |
| cfg_dinc_i | input | 1 | Destination address increment enable |
| start_i | input | 1 | Loads addresses and count and enables the channel (accepted when idle) |
| src_i | input | AW | Start source address |
| dst_i | input | AW | Start destination address |
| cnt_i | input | CW | Number of units |
| dreq_i | input | 1 | External transfer request (asynchronous) |
| bus_req_o | output | 1 | Bus cycle in progress |
| bus_we_o | output | 1 | 1 = write cycle, 0 = read cycle |
| bus_addr_o | output | AW | Bus address |
| bus_size_o | output | 2 | Bus transfer size code |
| bus_wdata_o | output | DW | Write data |
| bus_rdata_i | input | DW | Read data |
| bus_rdy_i | input | 1 | Slave ready; completes the cycle at this edge |
| dack_o | output | 1 | Device acknowledge strobe |
| done_o | output | 1 | Count exhausted |
| illegal_o | output | 1 | Current configuration is unsupported |
| cnt_o | output | CW | Remaining unit count |

## Verification
Most internal faults show up on the bus port within one unit. A wrong beat counter or size decode gives the wrong number of bus cycles or a wrong address step. A wrong address register shows up as a bad address on the next cycle. A lost read latch gives write data that does not match the value read. Request-detection faults show up only as a count of units, one or more units too many or too few after a pulse or a held level. That is why the bench counts cycles over a quiet interval, not only at the end of a run. A count or done fault appears at `cnt_o` and `done_o` a single cycle after the last unit.

// File: rtl/dma_chan_pkg.sv
// Shared types for the DMA channel sequencer.
// Assumes the size code of the bus is the same two-bit code as the configuration.
package dma_chan_pkg;

    typedef enum logic [1:0] {
        SZ_BYTE  = 2'b00,
        SZ_WORD  = 2'b01,
        SZ_LONG  = 2'b10,
        SZ_BLK16 = 2'b11
    } xfer_size_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_RD,
        ST_WR,
        ST_SG
    } chan_state_e;

    typedef struct packed {
        xfer_size_e size;
        logic       auto_req;
        logic       ack_mode;
        logic       single;
        logic       level;
        logic       src_inc;
        logic       dst_inc;
    } chan_cfg_t;

    // Number of longword beats in one 16-byte block.
    localparam int unsigned BLK_BEATS = 4;

    // Byte step of one bus transfer for a size code.
    function automatic logic [2:0] size_bytes(input xfer_size_e s);
        case (s)
            SZ_BYTE: return 3'd1;
            SZ_WORD: return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/dma_cfg_reg.sv
// Channel configuration register.
// Holds the settings written by the owner. Clears on reset and on full standby,
// keeps its value otherwise (including module stop). Flags the unsupported
// combination of a 16-byte unit with level-detected external requests.
module dma_cfg_reg
    import dma_chan_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      standby_i,
    input  logic      we_i,
    input  chan_cfg_t cfg_i,
    output chan_cfg_t cfg_o,
    output logic      illegal_o
);

    chan_cfg_t cfg_q;

    // Register the configuration; standby wipes it like a reset.
    always_ff @(posedge clk) begin
        if (!rst_n || standby_i) begin
            cfg_q <= '0;
        end else if (we_i) begin
            cfg_q <= cfg_i;
        end
    end

    // Unsupported: block size with a level-sampled external request.
    always_comb begin
        illegal_o = (cfg_q.size == SZ_BLK16) && !cfg_q.auto_req && cfg_q.level;
    end

    assign cfg_o = cfg_q;

endmodule

// File: rtl/dma_req_detect.sv
// External request detector.
// Synchronizes an asynchronous request through SYNC_STAGES flops (at least 2).
// Edge mode latches a pending request on a rising edge and clears it when a unit
// is taken; level mode passes the synchronized level straight through.
module dma_req_detect #(
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic dreq_i,
    input  logic level_i,
    input  logic flush_i,
    input  logic take_i,
    output logic req_o
);

    localparam int unsigned LAST = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;
    logic                   pend_q;
    logic                   rise;

    // Synchronizer chain, one flop per stage.
    for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
        if (g == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q[0] <= 1'b0;
                else        sync_q[0] <= dreq_i;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (!rst_n) sync_q[g] <= 1'b0;
                else        sync_q[g] <= sync_q[g-1];
            end
        end
    end

    // Previous synchronized level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sync_q[LAST];
    end

    assign rise = sync_q[LAST] & ~prev_q;

    // Pending edge request; a new edge wins over the take of an older one.
    always_ff @(posedge clk) begin
        if (!rst_n || flush_i) pend_q <= 1'b0;
        else if (rise)         pend_q <= 1'b1;
        else if (take_i)       pend_q <= 1'b0;
    end

    assign req_o = level_i ? sync_q[LAST] : pend_q;

endmodule

// File: rtl/dma_addr_ctr.sv
// Address and count registers of the channel.
// Loads all three on start, advances each address by the given step when told,
// and decrements the count once per completed unit. The sequencer never asks
// for a decrement at zero.
module dma_addr_ctr #(
    parameter int unsigned AW = 32,
    parameter int unsigned CW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic [AW-1:0] src_i,
    input  logic [AW-1:0] dst_i,
    input  logic [CW-1:0] cnt_i,
    input  logic          adv_src_i,
    input  logic          adv_dst_i,
    input  logic [AW-1:0] step_i,
    input  logic          dec_i,
    output logic [AW-1:0] src_o,
    output logic [AW-1:0] dst_o,
    output logic [CW-1:0] cnt_o
);

    logic [AW-1:0] src_q, dst_q;
    logic [CW-1:0] cnt_q;

    // Source address register.
    always_ff @(posedge clk) begin
        if (!rst_n)         src_q <= '0;
        else if (load_i)    src_q <= src_i;
        else if (adv_src_i) src_q <= src_q + step_i;
    end

    // Destination address register.
    always_ff @(posedge clk) begin
        if (!rst_n)         dst_q <= '0;
        else if (load_i)    dst_q <= dst_i;
        else if (adv_dst_i) dst_q <= dst_q + step_i;
    end

    // Remaining unit count.
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_q <= '0;
        else if (load_i) cnt_q <= cnt_i;
        else if (dec_i)  cnt_q <= cnt_q - CW'(1);
    end

    assign src_o = src_q;
    assign dst_o = dst_q;
    assign cnt_o = cnt_q;

endmodule

// File: rtl/dma_chan_seq.sv
// DMA channel transfer sequencer (top).
// Runs dual-address (read then write) or single-address (one cycle with DACK)
// units on a ready-handshaked bus master port. A 16-byte unit is four longword
// beats. Configuration and start are accepted only while idle. Assumes the bus
// slave keeps bus_rdata_i valid at the edge where bus_rdy_i is high.
module dma_chan_seq
    import dma_chan_pkg::*;
#(
    parameter int unsigned AW          = 32,
    parameter int unsigned DW          = 32,
    parameter int unsigned CW          = 16,
    parameter int unsigned SYNC_STAGES = 2
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          standby_i,
    input  logic          mstop_i,
    input  logic          cfg_we_i,
    input  logic [1:0]    cfg_size_i,
    input  logic          cfg_auto_i,
    input  logic          cfg_ackm_i,
    input  logic          cfg_single_i,
    input  logic          cfg_level_i,
    input  logic          cfg_sinc_i,
    input  logic          cfg_dinc_i,
    input  logic          start_i,
    input  logic [AW-1:0] src_i,
    input  logic [AW-1:0] dst_i,
    input  logic [CW-1:0] cnt_i,
    input  logic          dreq_i,
    output logic          bus_req_o,
    output logic          bus_we_o,
    output logic [AW-1:0] bus_addr_o,
    output logic [1:0]    bus_size_o,
    output logic [DW-1:0] bus_wdata_o,
    input  logic [DW-1:0] bus_rdata_i,
    input  logic          bus_rdy_i,
    output logic          dack_o,
    output logic          done_o,
    output logic          illegal_o,
    output logic [CW-1:0] cnt_o
);

    localparam int unsigned BW = $clog2(BLK_BEATS);

    chan_state_e   state_q;
    logic          en_q, done_q;
    logic [BW-1:0] beat_q;
    logic [DW-1:0] data_q;

    chan_cfg_t     cfg_in, cfg_q;
    logic          illegal;
    logic          is_idle, cfg_wr, load_w, can_run, launch, fin_zero;
    logic          ext_req, req_ok, rdy_ok, last_beat;
    logic          rd_done, wr_done, sg_done, unit_end;
    logic          adv_src, adv_dst;
    logic [AW-1:0] step_w, src_w, dst_w;
    logic [CW-1:0] cnt_w;

    // Pack the configuration inputs.
    always_comb begin
        cfg_in.size     = xfer_size_e'(cfg_size_i);
        cfg_in.auto_req = cfg_auto_i;
        cfg_in.ack_mode = cfg_ackm_i;
        cfg_in.single   = cfg_single_i;
        cfg_in.level    = cfg_level_i;
        cfg_in.src_inc  = cfg_sinc_i;
        cfg_in.dst_inc  = cfg_dinc_i;
    end

    assign is_idle = (state_q == ST_IDLE);
    assign cfg_wr  = cfg_we_i && is_idle && !standby_i;

    dma_cfg_reg u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .standby_i (standby_i),
        .we_i      (cfg_wr),
        .cfg_i     (cfg_in),
        .cfg_o     (cfg_q),
        .illegal_o (illegal)
    );

    // Sequencing decisions for the current cycle.
    always_comb begin
        load_w    = is_idle && start_i && !standby_i;
        can_run   = is_idle && !load_w && !cfg_we_i && en_q && !mstop_i
                    && !illegal && !standby_i;
        req_ok    = cfg_q.auto_req || ext_req;
        launch    = can_run && (cnt_w != '0) && req_ok;
        fin_zero  = can_run && (cnt_w == '0);
        rdy_ok    = bus_rdy_i && !standby_i;
        rd_done   = (state_q == ST_RD) && rdy_ok;
        wr_done   = (state_q == ST_WR) && rdy_ok;
        sg_done   = (state_q == ST_SG) && rdy_ok;
        last_beat = (cfg_q.size != SZ_BLK16) || (beat_q == BW'(BLK_BEATS - 1));
        unit_end  = (wr_done || sg_done) && last_beat;
        adv_src   = (rd_done || (sg_done && !cfg_q.ack_mode)) && cfg_q.src_inc;
        adv_dst   = (wr_done || (sg_done && cfg_q.ack_mode)) && cfg_q.dst_inc;
        step_w    = AW'(size_bytes(cfg_q.size));
    end

    dma_req_detect #(.SYNC_STAGES(SYNC_STAGES)) u_req (
        .clk     (clk),
        .rst_n   (rst_n),
        .dreq_i  (dreq_i),
        .level_i (cfg_q.level),
        .flush_i (load_w || standby_i),
        .take_i  (launch),
        .req_o   (ext_req)
    );

    dma_addr_ctr #(.AW(AW), .CW(CW)) u_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (load_w),
        .src_i     (src_i),
        .dst_i     (dst_i),
        .cnt_i     (cnt_i),
        .adv_src_i (adv_src),
        .adv_dst_i (adv_dst),
        .step_i    (step_w),
        .dec_i     (unit_end),
        .src_o     (src_w),
        .dst_o     (dst_w),
        .cnt_o     (cnt_w)
    );

    // Channel state machine: idle, dual read, dual write, single cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            en_q    <= 1'b0;
            done_q  <= 1'b0;
            beat_q  <= '0;
            data_q  <= '0;
        end else if (standby_i) begin
            state_q <= ST_IDLE;
            en_q    <= 1'b0;
            beat_q  <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (load_w) begin
                        en_q   <= !illegal;
                        done_q <= 1'b0;
                    end else if (fin_zero) begin
                        en_q   <= 1'b0;
                        done_q <= 1'b1;
                    end else if (launch) begin
                        state_q <= cfg_q.single ? ST_SG : ST_RD;
                        beat_q  <= '0;
                    end
                end
                ST_RD: begin
                    if (rd_done) begin
                        data_q  <= bus_rdata_i;
                        state_q <= ST_WR;
                    end
                end
                ST_WR: begin
                    if (wr_done) begin
                        if (last_beat) begin
                            state_q <= ST_IDLE;
                        end else begin
                            beat_q  <= beat_q + BW'(1);
                            state_q <= ST_RD;
                        end
                    end
                end
                default: begin
                    if (sg_done) begin
                        if (last_beat) state_q <= ST_IDLE;
                        else           beat_q  <= beat_q + BW'(1);
                    end
                end
            endcase
        end
    end

    // Bus and acknowledge outputs decoded from the state.
    always_comb begin
        bus_req_o   = !is_idle;
        bus_we_o    = (state_q == ST_WR) || ((state_q == ST_SG) && cfg_q.ack_mode);
        unique case (state_q)
            ST_RD:   bus_addr_o = src_w;
            ST_WR:   bus_addr_o = dst_w;
            ST_SG:   bus_addr_o = cfg_q.ack_mode ? dst_w : src_w;
            default: bus_addr_o = '0;
        endcase
        bus_size_o  = (cfg_q.size == SZ_BLK16) ? SZ_LONG : cfg_q.size;
        bus_wdata_o = data_q;
        dack_o      = ((state_q == ST_RD) && !cfg_q.ack_mode)
                   || ((state_q == ST_WR) && cfg_q.ack_mode)
                   || (state_q == ST_SG);
    end

    assign done_o    = done_q;
    assign illegal_o = illegal;
    assign cnt_o     = cnt_w;

endmodule

// File: rtl/dma_chan_seq_chk.sv
// Protocol checker for the DMA channel sequencer, bound to the top module.
// Assumes only the ports and two configuration bits of the top.
module dma_chan_seq_chk #(
    parameter int unsigned AW = 32,
    parameter int unsigned CW = 16
) (
    input logic          clk,
    input logic          rst_n,
    input logic          standby_i,
    input logic          start_i,
    input logic          bus_req_o,
    input logic          bus_we_o,
    input logic [AW-1:0] bus_addr_o,
    input logic          bus_rdy_i,
    input logic          dack_o,
    input logic          done_o,
    input logic          illegal_o,
    input logic [CW-1:0] cnt_o,
    input logic          cfg_single,
    input logic          cfg_ackm
);

    // R9: an unanswered bus cycle holds its request, address and direction.
    p_hold_cycle_r9: assert property (@(posedge clk) disable iff (!rst_n || standby_i)
        (bus_req_o && !bus_rdy_i) |=> (bus_req_o && $stable(bus_addr_o) && $stable(bus_we_o)));

    // R7: in dual-address mode DACK sits on the read or write cycle per ack mode.
    p_dack_cycle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (dack_o && !cfg_single) |-> (bus_we_o == cfg_ackm));

    // R8: DACK never appears outside a bus cycle.
    p_dack_in_bus_r8: assert property (@(posedge clk) disable iff (!rst_n)
        dack_o |-> bus_req_o);

    // R10: a finished channel runs no bus cycle.
    p_done_quiet_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !bus_req_o);

    // R3: an unsupported configuration never drives the bus.
    p_illegal_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
        illegal_o |-> !bus_req_o);

    // R10: outside a start, the count only steps down by one.
    p_cnt_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(start_i) && (cnt_o != $past(cnt_o))) |-> (cnt_o == $past(cnt_o) - CW'(1)));

endmodule

bind dma_chan_seq dma_chan_seq_chk #(.AW(AW), .CW(CW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .standby_i  (standby_i),
    .start_i    (start_i),
    .bus_req_o  (bus_req_o),
    .bus_we_o   (bus_we_o),
    .bus_addr_o (bus_addr_o),
    .bus_rdy_i  (bus_rdy_i),
    .dack_o     (dack_o),
    .done_o     (done_o),
    .illegal_o  (illegal_o),
    .cnt_o      (cnt_o),
    .cfg_single (cfg_q.single),
    .cfg_ackm   (cfg_q.ack_mode)
);

// File: tb/tb_dma_chan_seq.sv
// Bench for the DMA channel sequencer: sweeps mode, size, increment and bus
// latency under auto-request, then directed request, standby and stop cases.
module tb_dma_chan_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        standby_i = 1'b0, mstop_i = 1'b0;
    logic        cfg_we_i = 1'b0;
    logic [1:0]  cfg_size_i = '0;
    logic        cfg_auto_i = 1'b0, cfg_ackm_i = 1'b0, cfg_single_i = 1'b0;
    logic        cfg_level_i = 1'b0, cfg_sinc_i = 1'b0, cfg_dinc_i = 1'b0;
    logic        start_i = 1'b0;
    logic [31:0] src_i = '0, dst_i = '0;
    logic [15:0] cnt_i = '0;
    logic        dreq_i = 1'b0;
    logic        bus_req_o, bus_we_o, dack_o, done_o, illegal_o;
    logic [31:0] bus_addr_o, bus_wdata_o, bus_rdata_i;
    logic [1:0]  bus_size_o;
    logic        bus_rdy_i = 1'b0;
    logic [15:0] cnt_o;

    int tests = 0, fails = 0;

    always #10 clk = ~clk;

    dma_chan_seq dut (.*);

    function automatic logic [31:0] mem_val(input logic [31:0] a);
        return {a[15:0], ~a[15:0]};
    endfunction

    assign bus_rdata_i = mem_val(bus_addr_o);

    // Bus slave model and cycle recorder, sampling at the falling edge.
    int          lat = 0, wc = 0, n_rec = 0, stab_err = 0;
    bit          in_cyc = 0;
    logic [31:0] a0;
    logic        w0;
    logic        rec_we[64], rec_dack[64];
    logic [31:0] rec_addr[64], rec_wd[64];
    logic [1:0]  rec_sz[64];

    always @(negedge clk) begin
        if (bus_req_o) begin
            if (!in_cyc) begin a0 = bus_addr_o; w0 = bus_we_o; in_cyc = 1; end
            else if (bus_addr_o !== a0 || bus_we_o !== w0) stab_err++;
            if (wc == lat) begin
                bus_rdy_i = 1'b1;
                if (n_rec < 64) begin
                    rec_we[n_rec] = bus_we_o;   rec_dack[n_rec] = dack_o;
                    rec_addr[n_rec] = bus_addr_o; rec_wd[n_rec] = bus_wdata_o;
                    rec_sz[n_rec] = bus_size_o;
                end
                n_rec++; wc = 0; in_cyc = 0;
            end else begin
                bus_rdy_i = 1'b0; wc++;
            end
        end else begin
            bus_rdy_i = 1'b0; wc = 0; in_cyc = 0;
        end
    end

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic do_cfg(input int sz, au, ak, sg, lv, si, di);
        @(negedge clk);
        cfg_size_i = 2'(sz); cfg_auto_i = au[0]; cfg_ackm_i = ak[0];
        cfg_single_i = sg[0]; cfg_level_i = lv[0];
        cfg_sinc_i = si[0]; cfg_dinc_i = di[0]; cfg_we_i = 1'b1;
        @(negedge clk);
        cfg_we_i = 1'b0;
    endtask

    task automatic do_start(input logic [31:0] s, d, input int c);
        @(negedge clk);
        src_i = s; dst_i = d; cnt_i = 16'(c); start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
    endtask

    task automatic wait_done(input int lim);
        for (int i = 0; i < lim && !done_o; i++) @(negedge clk);
    endtask

    // One auto-request run; expected bus trace computed from R1, R2, R7, R8.
    task automatic run_sweep(input int sg, ak, sz, inc, lt);
        int nb, step, per, exp_n, mism, idx;
        logic [31:0] sa, da, s0, d0, fa, fe;
        logic [1:0] esz;
        lat = lt; n_rec = 0; stab_err = 0;
        s0 = 32'h0000_1000 + 32'(sz * 256); d0 = 32'h0004_0000;
        do_cfg(sz, 1, ak, sg, 0, inc, inc);
        do_start(s0, d0, 3);
        wait_done(600);
        nb   = (sz == 3) ? 4 : 1;
        step = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
        per  = sg ? 1 : 2;
        esz  = (sz == 3) ? 2'd2 : 2'(sz);
        exp_n = 3 * nb * per;
        mism = 0; fa = '0; fe = '0;
        for (int k = 0; k < 3 * nb; k++) begin
            sa = s0 + (inc ? 32'(k * step) : 32'd0);
            da = d0 + (inc ? 32'(k * step) : 32'd0);
            for (int p = 0; p < per; p++) begin
                logic ewe, edk; logic [31:0] ead;
                idx = k * per + p;
                if (!sg) begin
                    ewe = p[0]; ead = p ? da : sa; edk = (p == ak);
                end else begin
                    ewe = ak[0]; ead = ak ? da : sa; edk = 1'b1;
                end
                if (idx < n_rec && idx < 64) begin
                    if (rec_we[idx] !== ewe || rec_addr[idx] !== ead || rec_dack[idx] !== edk
                        || rec_sz[idx] !== esz || (!sg && p == 1 && rec_wd[idx] !== mem_val(sa))) begin
                        if (mism == 0) begin fa = rec_addr[idx]; fe = ead; end
                        mism++;
                    end
                end
            end
        end
        // R4 auto run; R2 four beats for a block
        chk(n_rec == exp_n, (sz == 3) ? "R2" : "R4",
            $sformatf("bus cycle count sg=%0d ak=%0d sz=%0d", sg, ak, sz), n_rec, exp_n);
        // R1 sizes/steps, R7 dual, R8 single
        chk(mism == 0, sg ? "R8" : "R7",
            $sformatf("trace (R1 step) sg=%0d ak=%0d sz=%0d inc=%0d", sg, ak, sz, inc), fa, fe);
        chk(done_o && cnt_o == 0, "R10", "done with zero count", {cnt_o, 15'd0, done_o}, 32'h1);
        chk(stab_err == 0, "R9", "cycle held until ready", stab_err, 0);
    endtask

    initial begin
        #(20 * 100000);
        fails++;
        $display("FAIL R10 watchdog: actual hung expected finished");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        cycles(4);
        rst_n = 1'b1;
        cycles(1);
        // R11 reset state
        chk(!bus_req_o && !dack_o && !done_o && !illegal_o && cnt_o == 0, "R11", "reset outputs",
            {bus_req_o, dack_o, done_o, illegal_o, 12'd0, cnt_o}, 0);

        for (int sg = 0; sg < 2; sg++)
            for (int ak = 0; ak < 2; ak++)
                for (int sz = 0; sz < 4; sz++)
                    for (int inc = 0; inc < 2; inc++)
                        for (int lt = 0; lt < 3; lt++)
                            run_sweep(sg, ak, sz, inc, lt);
        lat = 0;

        // R5 edge-detected requests
        do_cfg(0, 0, 0, 0, 0, 1, 1);
        do_start(32'h100, 32'h200, 5);
        n_rec = 0; cycles(15);
        chk(n_rec == 0, "R5", "no unit without edge", n_rec, 0);
        dreq_i = 1'b1; cycles(6); dreq_i = 1'b0; cycles(15);
        chk(n_rec == 2, "R5", "one unit per pulse", n_rec, 2);
        dreq_i = 1'b1; cycles(40);
        chk(n_rec == 4, "R5", "held high gives one unit", n_rec, 4);
        dreq_i = 1'b0; cycles(5);
        chk(cnt_o == 3, "R5", "count after two edges", cnt_o, 3);

        // R2 block size under edge requests: one pulse, four beats, one count
        do_cfg(3, 0, 0, 0, 0, 1, 1);
        do_start(32'h300, 32'h400, 2);
        n_rec = 0; dreq_i = 1'b1; cycles(4); dreq_i = 1'b0; cycles(30);
        chk(n_rec == 8 && cnt_o == 1, "R2", "edge block unit", {n_rec[15:0], cnt_o}, {16'd8, 16'd1});

        // R6 level-detected requests
        do_cfg(0, 0, 0, 0, 1, 1, 1);
        do_start(32'h500, 32'h600, 4);
        n_rec = 0; cycles(20);
        chk(n_rec == 0, "R6", "low level starts nothing", n_rec, 0);
        dreq_i = 1'b1; wait_done(200); dreq_i = 1'b0;
        chk(n_rec == 8 && done_o, "R6", "held level runs all units", n_rec, 8);

        // R3 illegal combination
        do_cfg(3, 0, 0, 0, 1, 1, 1);
        cycles(1);
        chk(illegal_o == 1'b1, "R3", "block with level flagged", illegal_o, 1);
        do_start(32'h700, 32'h800, 2);
        n_rec = 0; dreq_i = 1'b1; cycles(30); dreq_i = 1'b0;
        chk(n_rec == 0 && !done_o, "R3", "illegal channel quiet", {n_rec[15:0], 15'd0, done_o}, 0);
        do_cfg(3, 1, 0, 0, 1, 1, 1);
        cycles(1);
        chk(illegal_o == 1'b0, "R3", "block with auto legal", illegal_o, 0);

        // R10 zero count
        do_cfg(0, 1, 0, 0, 0, 1, 1);
        do_start(32'h900, 32'hA00, 0);
        n_rec = 0; cycles(6);
        chk(done_o && n_rec == 0, "R10", "zero count finishes idle", {n_rec[15:0], 15'd0, done_o}, 1);

        // R11 standby clears configuration
        do_cfg(2, 1, 1, 0, 0, 1, 1);
        @(negedge clk); standby_i = 1'b1; @(negedge clk); standby_i = 1'b0;
        do_start(32'hB00, 32'hC00, 1);
        n_rec = 0; cycles(20);
        chk(n_rec == 0, "R11", "auto bit cleared", n_rec, 0);
        dreq_i = 1'b1; cycles(4); dreq_i = 1'b0; cycles(20);
        chk(n_rec == 2, "R11", "edge unit after standby", n_rec, 2);
        chk(rec_sz[0] == 2'd0 && rec_dack[0] && !rec_we[0], "R11", "byte size, dack on read",
            {rec_sz[0], rec_dack[0], rec_we[0]}, 4'b0010);

        // R12 module stop holds progress and keeps configuration
        do_cfg(1, 1, 0, 0, 0, 1, 1);
        @(negedge clk); mstop_i = 1'b1;
        do_start(32'hD00, 32'hE00, 2);
        n_rec = 0; cycles(20);
        chk(n_rec == 0 && !done_o, "R12", "stopped channel idle", n_rec, 0);
        mstop_i = 1'b0; wait_done(100);
        chk(n_rec == 4 && done_o, "R12", "runs after release", n_rec, 4);
        chk(rec_sz[0] == 2'd1, "R12", "size kept through stop", rec_sz[0], 1);

        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule